// File: doc/BRIEF.md
# Selectable T1/E1 Line Code Codec

This block converts a serial NRZ bit stream into a pair of bipolar line rails, and converts a received pair of rails back into NRZ. Two static inputs choose the coding. With the coder disabled, bits pass through unchanged. With the coder enabled, the block applies either plain alternate-mark-inversion or a zero-substitution code. The substitution code is B8ZS when the T1/E1 select is low and HDB3 when it is high.

The encoder holds a short lookahead line of bits. When it sees a complete block of zeros, it rewrites that block into a substitution pattern before the bits reach the rails. The decoder keeps a matching line of received symbols and tracks the polarity of the last pulse. It recognises complete substitution patterns and turns them back into zeros. It reports any other polarity violation, and any symbol with both rails high, on a code-error output that is aligned with the affected bit. Mode inputs are expected to change only while reset is held.

Top module: `lineCodec`

## Requirements
- R1: With coderEn low, txPos carries txData delayed by the window length, txNeg stays low, rxData carries rxPos delayed by the window length, and codeErr stays low, whatever the level of amiSel.
- R2: The window length is 8 bit periods when e1Sel is 0 and 4 when e1Sel is 1, in every mode, for both the encoder and the decoder. For the first window-length cycles after reset, both tx rails are low.
- R3: In AMI mode (coderEn=1, amiSel=1), each one becomes a single pulse and each zero drives no pulse. txPos=1 is a positive pulse and txNeg=1 is a negative pulse, and the two are never high together. Pulse polarities alternate, and the first pulse after reset is positive.
- R4: In B8ZS mode (coderEn=1, amiSel=0, e1Sel=0), zeros are grouped into blocks of 8, counted greedily from the start of each zero run. Each block is sent as 000VB0VB. V has the same polarity as the pulse before it, and B has the opposite polarity.
- R5: In HDB3 mode (coderEn=1, amiSel=0, e1Sel=1), zeros are grouped greedily into blocks of 4. A block is sent as 000V when an odd number of B pulses has been sent since the last V, and as B00V otherwise. The count starts at zero after reset.
- R6: In a substitution mode, once the first pulse has been sent, no more than window-length minus one consecutive bit periods pass without a pulse.
- R7: The decoder turns every complete substitution pattern back into zeros, so a looped-back encoder stream decodes to the original data after 2×window+1 cycles with codeErr low.
- R8: In a coded mode, a pulse whose polarity equals that of the previous pulse, and which is not part of a complete substitution pattern, is decoded as a one with codeErr high in the same output cycle.
- R9: In a coded mode, a received symbol with both rails high is decoded as a one with codeErr high, and it counts as a positive pulse for the polarity tracking that follows.
- R10: While rstN is low, txPos, txNeg, rxData and codeErr are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| coderEn | input | 1 | 0 = transparent, 1 = coded |
| amiSel | input | 1 | In coded mode: 1 = plain AMI, 0 = substitution |
| e1Sel | input | 1 | 0 = T1 (B8ZS, window 8), 1 = E1 (HDB3, window 4) |
| txData | input | 1 | NRZ transmit bit |
| txPos | output | 1 | Positive transmit rail |
| txNeg | output | 1 | Negative transmit rail |
| rxPos | input | 1 | Positive receive rail |
| rxNeg | input | 1 | Negative receive rail |
| rxData | output | 1 | NRZ receive bit |
| codeErr | output | 1 | Code violation flag aligned with rxData |

## Verification
A wrong last-pulse polarity or B-pulse parity in the encoder shows on the rails at the next pulse. For HDB3 it also shows at the next substitution block, where 000V and B00V would be swapped. A stale or missing substitution tag shows within one window as a bad pulse on a zero bit. In the decoder, a wrong polarity state or a missed pattern match shows one window later as a spurious codeErr or a one in place of a zero. The reference model predicts every rail and output bit on every cycle, so each of these faults is reported at the first cycle in which it shows.

// File: rtl/lcPkg.sv
package lcPkg;
  localparam int B8ZS_LEN = 8;
  localparam int HDB3_LEN = 4;
  localparam int E1_OFF   = B8ZS_LEN - HDB3_LEN;

  typedef enum logic [1:0] {K_RAW = 2'd0, K_ZERO = 2'd1, K_B = 2'd2, K_V = 2'd3} slotKind_e;

  typedef struct packed {
    logic      raw;
    slotKind_e kind;
  } encSlot_t;

  typedef struct packed {
    logic mark;
    logic pol;
    logic viol;
    logic err;
  } decSlot_t;

  typedef struct packed {
    logic passThru;
    logic substOn;
    logic useE1;
  } lcMode_t;

  // Substitution slot kind at offset o inside a zero block
  function automatic slotKind_e substKind(input logic useE1, input int o, input logic wantB);
    if (useE1) begin
      if (o == HDB3_LEN - 1) return K_V;
      if (o == 0 && wantB)   return K_B;
      return K_ZERO;
    end
    if (o == 3 || o == 6) return K_V;
    if (o == 4 || o == 7) return K_B;
    return K_ZERO;
  endfunction
endpackage

// File: rtl/lcCtrl.sv
module lcCtrl
  import lcPkg::*;
(
  input  logic    coderEn,
  input  logic    amiSel,
  input  logic    e1Sel,
  output lcMode_t mode
);
  always_comb begin
    mode.passThru = !coderEn;
    mode.substOn  = coderEn && !amiSel;
    mode.useE1    = e1Sel;
  end
endmodule

// File: rtl/lcEncoder.sv
module lcEncoder
  import lcPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  lcMode_t mode,
  input  logic    txData,
  output logic    txPos,
  output logic    txNeg
);
  localparam int DEPTH = B8ZS_LEN;

  encSlot_t slots   [DEPTH];
  encSlot_t shifted [DEPTH];
  encSlot_t nxt     [DEPTH];
  logic lastPol, bParity;
  logic lastPolNx, parityNx, posNx, negNx, polOut, pulseB, pulseV, runFound;
  int headIdx;
  encSlot_t head;

  always_comb begin
    headIdx = mode.useE1 ? E1_OFF : 0;
    head    = slots[headIdx];
    pulseB  = !mode.passThru && ((head.kind == K_B) || (head.kind == K_RAW && head.raw));
    pulseV  = !mode.passThru && (head.kind == K_V);
    polOut  = pulseV ? lastPol : !lastPol;
    posNx   = mode.passThru ? head.raw : ((pulseB || pulseV) && polOut);
    negNx   = (pulseB || pulseV) && !polOut;
    lastPolNx = (pulseB || pulseV) ? polOut : lastPol;
    parityNx  = pulseV ? 1'b0 : (pulseB ? !bParity : bParity);

    for (int i = 0; i < DEPTH - 1; i++) shifted[i] = slots[i + 1];
    shifted[DEPTH - 1] = '{raw: txData, kind: K_RAW};

    runFound = mode.substOn;
    for (int i = 0; i < DEPTH; i++)
      if (i >= headIdx && (shifted[i].raw || shifted[i].kind != K_RAW)) runFound = 1'b0;

    for (int i = 0; i < DEPTH; i++) begin
      nxt[i] = shifted[i];
      if (runFound && i >= headIdx)
        nxt[i].kind = substKind(mode.useE1, i - headIdx, !parityNx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '{raw: 1'b0, kind: K_ZERO};
      lastPol <= 1'b0;
      bParity <= 1'b0;
      txPos   <= 1'b0;
      txNeg   <= 1'b0;
    end else begin
      slots   <= nxt;
      lastPol <= lastPolNx;
      bParity <= parityNx;
      txPos   <= posNx;
      txNeg   <= negNx;
    end
  end
endmodule

// File: rtl/lcDecoder.sv
module lcDecoder
  import lcPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  lcMode_t mode,
  input  logic    rxPos,
  input  logic    rxNeg,
  output logic    rxData,
  output logic    codeErr
);
  localparam int DEPTH = B8ZS_LEN;

  decSlot_t slots   [DEPTH];
  decSlot_t shifted [DEPTH];
  decSlot_t nxt     [DEPTH];
  decSlot_t inSym, head;
  logic rxLastPol, match;

  function automatic logic isZ(input decSlot_t s);
    return !s.mark;
  endfunction
  function automatic logic isB(input decSlot_t s);
    return s.mark && !s.viol && !s.err;
  endfunction

  always_comb begin
    inSym.mark = mode.passThru ? rxPos : (rxPos || rxNeg);
    inSym.err  = !mode.passThru && rxPos && rxNeg;
    inSym.pol  = rxPos;
    inSym.viol = !mode.passThru && inSym.mark && !inSym.err && (rxPos == rxLastPol);

    for (int i = 0; i < DEPTH - 1; i++) shifted[i] = slots[i + 1];
    shifted[DEPTH - 1] = inSym;

    if (mode.useE1)
      match = (isZ(shifted[E1_OFF]) || isB(shifted[E1_OFF])) && isZ(shifted[E1_OFF + 1])
              && isZ(shifted[E1_OFF + 2]) && shifted[E1_OFF + 3].viol;
    else
      match = isZ(shifted[0]) && isZ(shifted[1]) && isZ(shifted[2]) && shifted[3].viol
              && isB(shifted[4]) && isZ(shifted[5]) && shifted[6].viol && isB(shifted[7]);
    match = match && mode.substOn;

    for (int i = 0; i < DEPTH; i++) begin
      nxt[i] = shifted[i];
      if (match && (!mode.useE1 || i >= E1_OFF)) nxt[i] = '0;
    end
    head = mode.useE1 ? slots[E1_OFF] : slots[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      rxLastPol <= 1'b0;
      rxData    <= 1'b0;
      codeErr   <= 1'b0;
    end else begin
      slots <= nxt;
      if (!mode.passThru && inSym.mark) rxLastPol <= inSym.pol;
      rxData  <= head.mark;
      codeErr <= head.viol || head.err;
    end
  end
endmodule

// File: rtl/lineCodec.sv
module lineCodec
  import lcPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic coderEn,
  input  logic amiSel,
  input  logic e1Sel,
  input  logic txData,
  output logic txPos,
  output logic txNeg,
  input  logic rxPos,
  input  logic rxNeg,
  output logic rxData,
  output logic codeErr
);
  lcMode_t mode;

  lcCtrl u_ctrl (
    .coderEn(coderEn), .amiSel(amiSel), .e1Sel(e1Sel), .mode(mode)
  );

  lcEncoder u_enc (
    .clk(clk), .rstN(rstN), .mode(mode), .txData(txData), .txPos(txPos), .txNeg(txNeg)
  );

  lcDecoder u_dec (
    .clk(clk), .rstN(rstN), .mode(mode), .rxPos(rxPos), .rxNeg(rxNeg),
    .rxData(rxData), .codeErr(codeErr)
  );
endmodule

// File: rtl/lineCodec_chk.sv
module lineCodec_chk
  import lcPkg::*;
(
  input logic clk,
  input logic rstN,
  input logic coderEn,
  input logic amiSel,
  input logic e1Sel,
  input logic txPos,
  input logic txNeg,
  input logic codeErr
);
  logic       lastP, seenPulse;
  logic [3:0] zeroRun;
  logic       anyPulse;
  int         winLen;

  assign anyPulse = txPos || txNeg;
  assign winLen   = e1Sel ? HDB3_LEN : B8ZS_LEN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastP     <= 1'b0;
      seenPulse <= 1'b0;
      zeroRun   <= '0;
    end else begin
      if (anyPulse) begin
        lastP     <= txPos;
        seenPulse <= 1'b1;
        zeroRun   <= '0;
      end else if (zeroRun != 4'hF) begin
        zeroRun <= zeroRun + 4'd1;
      end
    end
  end

  p_rails_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(txPos && txNeg));

  p_ami_alternate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (coderEn && amiSel && anyPulse) |-> (txPos != lastP));

  p_transparent_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !coderEn |=> (!txNeg && !codeErr));

  p_zero_run_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (coderEn && !amiSel && seenPulse && !anyPulse) |-> (int'(zeroRun) < winLen - 1));
endmodule

bind lineCodec lineCodec_chk u_chk (.*);

// File: tb/lineCodec_tb.sv
module lineCodec_tb;
  import lcPkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_LEN    = 320;
  localparam int MAXB       = 400;

  logic clk = 1'b0, rstN = 1'b0, coderEn = 1'b0, amiSel = 1'b0, e1Sel = 1'b0;
  logic txData = 1'b0, drvPos = 1'b0, drvNeg = 1'b0, loopOn = 1'b0;
  logic rxPos, rxNeg, txPos, txNeg, rxData, codeErr;

  assign rxPos = loopOn ? txPos : drvPos;
  assign rxNeg = loopOn ? txNeg : drvNeg;

  lineCodec u_dut (
    .clk(clk), .rstN(rstN), .coderEn(coderEn), .amiSel(amiSel), .e1Sel(e1Sel),
    .txData(txData), .txPos(txPos), .txNeg(txNeg), .rxPos(rxPos), .rxNeg(rxNeg),
    .rxData(rxData), .codeErr(codeErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;
  bit inBits[MAXB], blkStart[MAXB], dP[MAXB], dN[MAXB], expD[MAXB], expE[MAXB];
  int win, zc, blkPos;
  bit mPass, mSubst, mLastPol, mParity, blkB00V;
  string dirTag;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  function automatic bit genBit(input int n);
    int k = n % 64;
    if (k < 19) return 1'b0;
    if (k < 24) return 1'b1;
    if (k < 29) return 1'b0;
    return ($urandom % 3) == 0;
  endfunction

  task automatic driveBit(input int n);
    bit b = genBit(n);
    inBits[n] = b;
    txData = b;
    if (mSubst) begin
      if (b) zc = 0;
      else begin
        zc++;
        if (zc == win) begin
          blkStart[n - win + 1] = 1'b1;
          zc = 0;
        end
      end
    end
  endtask

  // Behavioural encoder reference: emits bit m in order
  task automatic emit(input int m, output bit pos, output bit neg);
    int kind;  // 0 none, 1 B, 2 V
    bit pol;
    kind = 0;
    if (mPass) begin
      pos = inBits[m]; neg = 1'b0;
      return;
    end
    if (blkStart[m]) begin
      blkPos = 0;
      blkB00V = !mParity;
    end
    if (blkPos >= 0) begin
      if (e1Sel) kind = (blkPos == 3) ? 2 : ((blkPos == 0 && blkB00V) ? 1 : 0);
      else kind = (blkPos == 3 || blkPos == 6) ? 2 : ((blkPos == 4 || blkPos == 7) ? 1 : 0);
      blkPos++;
      if (blkPos == win) blkPos = -1;
    end else if (inBits[m]) kind = 1;
    pos = 1'b0; neg = 1'b0;
    if (kind == 1) begin
      pol = !mLastPol; mLastPol = pol; mParity = !mParity;
      pos = pol; neg = !pol;
    end else if (kind == 2) begin
      pol = mLastPol; mParity = 1'b0;
      pos = pol; neg = !pol;
    end
  endtask

  function automatic string txTag();
    if (mPass) return "R1";
    if (!mSubst) return "R3";
    return e1Sel ? "R5" : "R4";
  endfunction

  task automatic startRun(input bit ce, input bit ami, input bit e1, input bit loop);
    rstN = 1'b0;
    coderEn = ce; amiSel = ami; e1Sel = e1; loopOn = loop;
    drvPos = 1'b0; drvNeg = 1'b0; txData = 1'b0;
    mPass = !ce; mSubst = ce && !ami;
    win = e1 ? HDB3_LEN : B8ZS_LEN;
    zc = 0; blkPos = -1; mLastPol = 1'b0; mParity = 1'b0; blkB00V = 1'b0;
    for (int i = 0; i < MAXB; i++) begin
      inBits[i] = 0; blkStart[i] = 0; dP[i] = 0; dN[i] = 0; expD[i] = 0; expE[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "txPos in reset", txPos, 1'b0);
    check("R10", "txNeg in reset", txNeg, 1'b0);
    check("R10", "rxData in reset", rxData, 1'b0);
    check("R10", "codeErr in reset", codeErr, 1'b0);
  endtask

  task automatic runCycles(input int n, input bit directed);
    bit ePos, eNeg;
    int idx;
    rstN = 1'b1;
    if (directed) begin drvPos = dP[0]; drvNeg = dN[0]; end
    else driveBit(0);
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      if (!directed) begin
        if (p - win >= 0) begin
          emit(p - win, ePos, eNeg);
          check(txTag(), "txPos", txPos, ePos);
          check(txTag(), "txNeg", txNeg, eNeg);
        end else begin
          check("R2", "txPos before window filled", txPos, 1'b0);
          check("R2", "txNeg before window filled", txNeg, 1'b0);
        end
        idx = p - 2 * win - 1;
        check(mPass ? "R1" : "R7", "rxData loopback", rxData, (idx >= 0) ? inBits[idx] : 1'b0);
        check(mPass ? "R1" : "R8", "codeErr loopback", codeErr, 1'b0);
      end else begin
        idx = p - win;
        check("R7", "rxData directed", rxData, (idx >= 0) ? expD[idx] : 1'b0);
        check(dirTag, "codeErr directed", codeErr, (idx >= 0) ? expE[idx] : 1'b0);
      end
      if (directed) begin drvPos = dP[p + 1]; drvNeg = dN[p + 1]; end
      else driveBit(p + 1);
    end
  endtask

  initial begin
    // R1: transparent, amiSel high and low must not matter
    startRun(1'b0, 1'b1, 1'b0, 1'b1); runCycles(RUN_LEN, 1'b0);
    startRun(1'b0, 1'b0, 1'b1, 1'b1); runCycles(RUN_LEN, 1'b0);
    // R3 and R2: AMI with both window lengths
    startRun(1'b1, 1'b1, 1'b0, 1'b1); runCycles(RUN_LEN, 1'b0);
    startRun(1'b1, 1'b1, 1'b1, 1'b1); runCycles(RUN_LEN, 1'b0);
    // R4, R6, R7: B8ZS loopback
    startRun(1'b1, 1'b0, 1'b0, 1'b1); runCycles(RUN_LEN, 1'b0);
    // R5, R6, R7: HDB3 loopback
    startRun(1'b1, 1'b0, 1'b1, 1'b1); runCycles(RUN_LEN, 1'b0);

    // R8, R9: AMI receive with a repeated polarity and a both-rails symbol
    startRun(1'b1, 1'b1, 1'b0, 1'b0);
    dirTag = "R8 R9";
    dP[0] = 1; dN[2] = 1; dN[3] = 1; dP[4] = 1; dP[5] = 1; dN[5] = 1; dN[6] = 1;
    expD[0] = 1; expD[2] = 1; expD[3] = 1; expD[4] = 1; expD[5] = 1; expD[6] = 1;
    expE[3] = 1; expE[5] = 1;
    runCycles(40, 1'b1);

    // R7, R8: HDB3 receive, one valid B00V removed, one stray violation flagged
    startRun(1'b1, 1'b0, 1'b1, 1'b0);
    dirTag = "R8";
    dP[0] = 1; dN[1] = 1; dN[4] = 1; dP[5] = 1; dP[7] = 1;
    expD[0] = 1; expD[5] = 1; expD[7] = 1;
    expE[7] = 1;
    runCycles(30, 1'b1);

    finishUp();
  end
endmodule